// File: doc/BRIEF.md
# IR Carrier Period and Width Meter

This block measures the carrier of a modulated infrared receive signal. The raw receiver output is optionally inverted, passed through a synchronizer, and its rising edges are timed on a coarse tick of `TICK_DIV` clock cycles. `TICK_DIV` is chosen so that one tick lasts 500 ns at the design clock. The tick prescaler restarts on every rising edge, so a stretch of P clock cycles measured from a rising edge counts as floor(P / `TICK_DIV`) ticks.

A burst begins at the first rising edge seen while idle. Every later rising edge completes one carrier pulse. That pulse's period is the tick count between its two rising edges, and its high time is the tick count from its rising edge to the following falling edge. The first few completed pulses are skipped to let the receiver settle. The next group of pulses is summed, and both sums are divided by the group size. The two averages are then loaded into the output registers together, with a valid flag. The result stays on the outputs until another burst completes.

The configuration byte and the polarity control are read by the block. Consumers read the two result bytes directly.

Top module: `ir_carrier_meter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `period_o` and `width_o` are both 0x00.
- R2: `period_o[6:0]` holds floor(sum of averaged pulse periods / N). Each pulse period is floor(clock cycles between consecutive rising edges / `TICK_DIV`) ticks.
- R3: `width_o[6:0]` holds floor(sum of averaged high times / N). Each high time is floor(clock cycles from a rising edge to the next falling edge / `TICK_DIV`). `width_o[7]` is always 0.
- R4: `cfg_i[7:4]` gives D, the number of completed pulses at the start of a burst that are left out of the averages (0 to 15). It is captured at the first edge of the burst.
- R5: `cfg_i[3:0]` gives N, the number of completed pulses averaged after the skipped ones. A value of 0 averages a single pulse.
- R6: `period_o[7]` is the valid flag. It is set when a result is loaded and never clears afterwards without a reset. The outputs only change together with a valid flag of 1.
- R7: With `pol_inv_i` at 1 the input is inverted ahead of the synchronizer. The measured rising edges are then the falling edges of `ir_raw_i`.
- R8: A gap of more than 255 ticks without a rising edge ends the burst. The skip and average progress is discarded, and an incomplete burst leaves both outputs unchanged.
- R9: Once a burst has produced its result, further pulses in that burst are ignored. The result is held until a later burst completes.
- R10: An averaged period or high time above 127 ticks is reported as 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_raw_i | input | 1 | Raw, asynchronous receiver signal |
| pol_inv_i | input | 1 | 1 inverts the input before measurement |
| cfg_i | input | 8 | [7:4] pulses skipped, [3:0] pulses averaged |
| period_o | output | 8 | [7] valid, [6:0] averaged carrier period in ticks |
| width_o | output | 8 | [7] zero, [6:0] averaged high time in ticks |

## Verification
The simplest stimulus is a steady single-pulse burst, which shows that the basic tick arithmetic is right. A burst whose periods and high times alternate shows truncating division over a sum, as opposed to reporting the last pulse. Two further bursts each have a settling head or a tail with values very different from the averaged group. These show that the skip count, and the freeze after completion, pick exactly the intended pulses. Separate bursts cover the following cases:
- N = 0.
- The full 15/15 configuration.
- Inverted polarity.
- Values beyond 127 ticks.
- A short burst followed by a long gap, which must leave the held result untouched and must not carry its pulses into the next burst.

// File: rtl/ircm_pkg.sv
package ircm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DIV,
    ST_HOLD
  } meas_st_t;
endpackage

// File: rtl/ircm_tick.sv
module ircm_tick #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) pre <= '0;
    else if (tick)      pre <= '0;
    else                pre <= pre + 1'b1;
  end
endmodule

// File: rtl/ircm_sync.sv
module ircm_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic inv_i,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sh;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], raw_i ^ inv_i};
      prev <= sh[SYNC_STAGES-1];
    end
  end

  assign rise = sh[SYNC_STAGES-1] & ~prev;
  assign fall = ~sh[SYNC_STAGES-1] & prev;
endmodule

// File: rtl/ircm_div.sv
module ircm_div #(
  parameter int DW = 12,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quot
);
  localparam int CW = $clog2(DW + 1);

  logic          busy;
  logic [CW-1:0] left;
  logic [VW-1:0] rem;
  logic [DW-1:0] q;
  logic [VW:0]   trial;
  logic          ge;

  assign trial = {rem, q[DW-1]};
  assign ge    = (trial >= {1'b0, divisor});
  assign quot  = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
      rem  <= '0;
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        left <= CW'(DW);
        rem  <= '0;
        q    <= dividend;
      end else if (busy) begin
        q    <= {q[DW-2:0], ge};
        rem  <= ge ? VW'(trial - {1'b0, divisor}) : trial[VW-1:0];
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter
  import ircm_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int NIB_W       = 4,
  parameter int OUT_W       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ir_raw_i,
  input  logic               pol_inv_i,
  input  logic [2*NIB_W-1:0] cfg_i,
  output logic [OUT_W:0]     period_o,
  output logic [OUT_W:0]     width_o
);
  localparam int SUM_W = CNT_W + NIB_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SUM_W-1:0] OUT_MAX = SUM_W'((1 << OUT_W) - 1);

  logic             rise, fall, tick;
  logic [CNT_W-1:0] gap_cnt, hi_cnt, per_smp;
  logic             hi_run, timeout, last_avg;
  meas_st_t         st;
  logic [NIB_W-1:0] disc_lim, avg_lim, disc_cnt, avg_cnt;
  logic [SUM_W-1:0] sum_p, sum_w;
  logic             div_go, res_done;
  logic [1:0][SUM_W-1:0] dvd, quo;
  logic [1:0][OUT_W-1:0] res;
  logic [1:0]            dn;

  ircm_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(ir_raw_i), .inv_i(pol_inv_i),
    .rise(rise), .fall(fall)
  );

  ircm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(rise), .tick(tick)
  );

  // Tick counters: gap since last rising edge, high time of current pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      hi_cnt  <= '0;
      hi_run  <= 1'b0;
    end else if (rise) begin
      gap_cnt <= '0;
      hi_cnt  <= '0;
      hi_run  <= 1'b1;
    end else begin
      if (tick && gap_cnt != CNT_MAX) gap_cnt <= gap_cnt + 1'b1;
      if (hi_run && tick && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
      if (fall) hi_run <= 1'b0;
    end
  end

  assign timeout  = tick && (gap_cnt == CNT_MAX);
  assign per_smp  = gap_cnt + {{(CNT_W-1){1'b0}}, tick};
  assign last_avg = ((avg_cnt + 1'b1) == avg_lim);

  assign dvd[0] = sum_p;
  assign dvd[1] = sum_w;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    ircm_div #(.DW(SUM_W), .VW(NIB_W)) u_div (
      .clk(clk), .rst(rst), .start(div_go), .dividend(dvd[g]),
      .divisor(avg_lim), .done(dn[g]), .quot(quo[g])
    );
    assign res[g] = (quo[g] > OUT_MAX) ? OUT_MAX[OUT_W-1:0] : quo[g][OUT_W-1:0];
  end

  assign res_done = &dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      disc_lim <= '0;
      avg_lim  <= NIB_W'(1);
      disc_cnt <= '0;
      avg_cnt  <= '0;
      sum_p    <= '0;
      sum_w    <= '0;
      div_go   <= 1'b0;
      period_o <= '0;
      width_o  <= '0;
    end else begin
      div_go <= 1'b0;
      unique case (st)
        ST_IDLE: if (rise) begin
          disc_lim <= cfg_i[2*NIB_W-1:NIB_W];
          avg_lim  <= (cfg_i[NIB_W-1:0] == '0) ? NIB_W'(1) : cfg_i[NIB_W-1:0];
          disc_cnt <= '0;
          avg_cnt  <= '0;
          sum_p    <= '0;
          sum_w    <= '0;
          st       <= ST_RUN;
        end
        ST_RUN: if (timeout) begin
          st <= ST_IDLE;
        end else if (rise) begin
          if (disc_cnt != disc_lim) begin
            disc_cnt <= disc_cnt + 1'b1;
          end else begin
            sum_p   <= sum_p + SUM_W'(per_smp);
            sum_w   <= sum_w + SUM_W'(hi_cnt);
            avg_cnt <= avg_cnt + 1'b1;
            if (last_avg) begin
              div_go <= 1'b1;
              st     <= ST_DIV;
            end
          end
        end
        ST_DIV: if (res_done) begin
          period_o <= {1'b1, res[0]};
          width_o  <= {1'b0, res[1]};
          st       <= ST_HOLD;
        end
        ST_HOLD: if (timeout) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ircm_chk.sv
module ircm_chk #(
  parameter int OUT_W = 7
) (
  input logic           clk,
  input logic           rst,
  input logic [OUT_W:0] period_o,
  input logic [OUT_W:0] width_o,
  input logic           res_done
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (period_o == '0 && width_o == '0));

  p_width_le_period_r3: assert property (@(posedge clk) disable iff (rst)
    period_o[OUT_W] |-> (width_o[OUT_W-1:0] <= period_o[OUT_W-1:0]));

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    $past(period_o[OUT_W]) |-> period_o[OUT_W]);

  p_change_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable({period_o, width_o}) |-> period_o[OUT_W]);

  p_change_after_div_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable({period_o, width_o}) |-> $past(res_done));
endmodule

bind ir_carrier_meter ircm_chk u_chk (
  .clk(clk), .rst(rst), .period_o(period_o), .width_o(width_o), .res_done(res_done)
);

// File: tb/tb_ir_carrier_meter.sv
module tb_ir_carrier_meter;
  localparam int CLK_NS = 10;
  localparam int TDIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lvl = 1'b0;
  logic inv = 1'b0;
  logic ir_raw_i, pol_inv_i;
  logic [7:0] cfg_i = 8'h00;
  logic [7:0] period_o, width_o;

  assign ir_raw_i  = lvl ^ inv;
  assign pol_inv_i = inv;

  always #(CLK_NS/2) clk = ~clk;

  ir_carrier_meter #(.TICK_DIV(TDIV)) dut (
    .clk(clk), .rst(rst), .ir_raw_i(ir_raw_i), .pol_inv_i(pol_inv_i),
    .cfg_i(cfg_i), .period_o(period_o), .width_o(width_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int per_a[32];
  int hi_a[32];
  logic [15:0] exp_q[$];
  logic [15:0] last_exp = 16'h0000;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output update.
  initial begin
    logic [15:0] seen;
    seen = 16'h0000;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && {period_o, width_o} !== seen) begin
        seen = {period_o, width_o};
        if (exp_q.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R9 unexpected update actual=%h expected=none", seen);
        end else begin
          check("R2 R3 scoreboard", seen, exp_q.pop_front());
        end
      end
    end
  end

  task automatic fill(input int from, input int upto, input int p, input int h);
    for (int i = from; i <= upto; i++) begin
      per_a[i] = p;
      hi_a[i]  = h;
    end
  endtask

  task automatic push_exp(input int n, input int d, input int nv);
    int neff, sp, sw;
    neff = (nv == 0) ? 1 : nv;
    if (n - 1 >= d + neff) begin
      sp = 0;
      sw = 0;
      for (int i = d; i < d + neff; i++) begin
        sp += per_a[i] / TDIV;
        sw += hi_a[i] / TDIV;
      end
      sp = sp / neff;
      sw = sw / neff;
      if (sp > 127) sp = 127;
      if (sw > 127) sw = 127;
      last_exp = {1'b1, sp[6:0], 1'b0, sw[6:0]};
      exp_q.push_back(last_exp);
    end
  endtask

  task automatic burst(input string tag, input int d, input int nv, input int n, input logic iv);
    inv = iv;
    repeat (4) @(negedge clk);
    cfg_i = {d[3:0], nv[3:0]};
    push_exp(n, d, nv);
    for (int i = 0; i < n; i++) begin
      lvl = 1'b1;
      repeat (hi_a[i]) @(negedge clk);
      lvl = 1'b0;
      repeat (per_a[i] - hi_a[i]) @(negedge clk);
    end
    repeat (1200) @(negedge clk);
    check({tag, " drained"}, 16'(exp_q.size()), 16'h0000);
    check({tag, " held"}, {period_o, width_o}, last_exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 in reset", {period_o, width_o}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {period_o, width_o}, 16'h0000);

    fill(0, 1, 40, 20);
    burst("R2 R3 R6 single", 0, 1, 2, 1'b0);

    fill(0, 1, 80, 8);
    per_a[2] = 40; hi_a[2] = 12;
    per_a[3] = 44; hi_a[3] = 17;
    per_a[4] = 40; hi_a[4] = 13;
    per_a[5] = 46; hi_a[5] = 18;
    per_a[6] = 40; hi_a[6] = 20;
    burst("R4 R2 alternating", 2, 4, 7, 1'b0);

    fill(0, 0, 100, 50);
    fill(1, 2, 60, 30);
    burst("R5 zero count", 1, 0, 3, 1'b0);

    per_a[0] = 48; hi_a[0] = 24;
    per_a[1] = 52; hi_a[1] = 20;
    per_a[2] = 48; hi_a[2] = 24;
    burst("R7 inverted", 0, 2, 3, 1'b1);

    fill(0, 2, 120, 60);
    burst("R8 partial", 2, 2, 3, 1'b0);
    fill(0, 1, 100, 20);
    fill(2, 4, 72, 36);
    burst("R8 after gap", 2, 2, 5, 1'b0);

    fill(0, 1, 64, 16);
    fill(2, 5, 200, 100);
    burst("R9 tail ignored", 0, 2, 6, 1'b0);

    fill(0, 1, 600, 540);
    burst("R10 saturate", 0, 1, 2, 1'b0);

    fill(0, 14, 200, 100);
    fill(15, 30, 36, 12);
    burst("R4 R5 max nibbles", 15, 15, 31, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule